// File: doc/BRIEF.md
# Double-Precision Maximum/Minimum Selector

The block takes two IEEE-754 binary64 operands and returns either the larger or the smaller one. A mode input chooses one of two conventions for NaNs and signed zeros. The compare convention hands back operand B whenever a NaN is present. The language convention returns the first NaN it finds, checking A before B, and it orders -0 below +0. The result is always one of the two operands bit for bit, or a canonical zero, so a NaN is never quieted or altered.

Alongside the result the block raises a signaling-NaN flag. It also drives a destination write-enable, which is withheld when a signaling NaN meets an enabled invalid-operation trap. The unit is combinational. An optional output register, on by default, adds one cycle of latency and sits behind a reset that is asserted asynchronously and released synchronously.

Top module: `fpmm_top`

## Requirements
- R1: In compare mode (sel_jmode=0), if either operand is a NaN, res_o is op_b unchanged. snan_o is 1 if either operand is a signaling NaN.
- R2: In compare mode with no NaN input, max (sel_max=1) returns op_a unless op_a < op_b, and min (sel_max=0) returns op_a only when op_a < op_b. In every other case op_b is returned, so equal values, including +0 against -0, give op_a for max and op_b for min.
- R3: In language mode (sel_jmode=1), a NaN in op_a is returned and only op_a's signaling state sets snan_o. Otherwise a NaN in op_b is returned and op_b's signaling state sets snan_o.
- R4: In language mode max, when both operands are zeros, res_o is 0x8000000000000000 if both are negative and 0x0000000000000000 otherwise.
- R5: In language mode min, when both operands are zeros, res_o is 0x8000000000000000 if either is negative and 0x0000000000000000 otherwise.
- R6: In language mode, when no operand is a NaN and the operands are not both zeros, the selection follows the rule of R2.
- R7: wr_en_o is 0 exactly when snan_o is 1 and inv_en was 1 for the same operation. Otherwise it is 1.
- R8: A NaN has exponent bits 62:52 all ones and a nonzero fraction in bits 51:0, and it is signaling when bit 51 is 0. Infinities take part in ordering, and any NaN result is bit-exact.
- R9: The ordering is by sign and magnitude. Any negative value is below any positive value, a larger magnitude is lower among negatives, and +0 equals -0.
- R10: With the output register present, the result of inputs applied before a clock edge appears after that edge. While reset is held, res_o=0, snan_o=0 and wr_en_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| op_a | input | 64 | Operand A, binary64 |
| op_b | input | 64 | Operand B, binary64 |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| sel_jmode | input | 1 | 1 selects the language convention, 0 the compare convention |
| inv_en | input | 1 | Invalid-operation trap enable |
| res_o | output | 64 | Selected result |
| snan_o | output | 1 | Signaling-NaN invalid flag |
| wr_en_o | output | 1 | Destination write-enable |

## Verification
The bench goes after the cases where the two conventions diverge. In compare mode, a design that lets A win on a NaN returns the wrong operand. In language mode, one that lets B win, or that flags a signaling NaN in B which was never examined, raises a spurious flag. Signed-zero pairs are driven in all four sign combinations and both directions: a design that compares zeros by raw bits returns -0 from max or +0 from min in language mode, and one that breaks ties the wrong way swaps A and B in compare mode. Mixed-sign, negative-magnitude and infinity operands catch a comparator that treats the encoding as an unsigned integer. Signaling NaNs under both trap settings expose a write-enable that is suppressed at the wrong time.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_class_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output fpmm_pkg::fp_class_t   cls
);
  localparam int MSB = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones;
  logic              frac_nz;

  always_comb begin
    expo        = val[MSB-1:FRAC_W];
    frac        = val[FRAC_W-1:0];
    exp_ones    = &expo;
    frac_nz     = |frac;
    cls.sign    = val[MSB];
    cls.is_nan  = exp_ones & frac_nz;
    cls.is_snan = exp_ones & frac_nz & ~frac[FRAC_W-1];
    cls.is_zero = ~(|expo) & ~frac_nz;
  end
endmodule

// File: rtl/fpmm_less.sv
module fpmm_less #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  fpmm_pkg::fp_class_t   ca,
  input  fpmm_pkg::fp_class_t   cb,
  output logic                  a_lt_b
);
  localparam int MSB = EXP_W + FRAC_W;

  logic [MSB-1:0] mag_a;
  logic [MSB-1:0] mag_b;

  always_comb begin
    mag_a = a[MSB-1:0];
    mag_b = b[MSB-1:0];
    if (ca.is_zero && cb.is_zero) begin
      a_lt_b = 1'b0;
    end else if (ca.sign != cb.sign) begin
      a_lt_b = ca.sign;
    end else if (ca.sign) begin
      a_lt_b = mag_a > mag_b;
    end else begin
      a_lt_b = mag_a < mag_b;
    end
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  fpmm_pkg::fp_class_t   ca,
  input  fpmm_pkg::fp_class_t   cb,
  input  logic                  a_lt_b,
  input  logic                  sel_max,
  input  logic                  sel_jmode,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  snan
);
  localparam int DW = EXP_W + FRAC_W + 1;
  localparam logic [DW-1:0] POS_ZERO = '0;
  localparam logic [DW-1:0] NEG_ZERO = {1'b1, {(DW-1){1'b0}}};

  logic take_a;

  always_comb begin
    take_a = sel_max ? ~a_lt_b : a_lt_b;
    snan   = 1'b0;
    res    = take_a ? a : b;
    if (!sel_jmode) begin
      if (ca.is_nan || cb.is_nan) begin
        res  = b;
        snan = ca.is_snan | cb.is_snan;
      end
    end else begin
      if (ca.is_nan) begin
        res  = a;
        snan = ca.is_snan;
      end else if (cb.is_nan) begin
        res  = b;
        snan = cb.is_snan;
      end else if (ca.is_zero && cb.is_zero) begin
        if (sel_max) begin
          res = (ca.sign & cb.sign) ? NEG_ZERO : POS_ZERO;
        end else begin
          res = (ca.sign | cb.sign) ? NEG_ZERO : POS_ZERO;
        end
      end
    end
  end
endmodule

// File: rtl/fpmm_top.sv
module fpmm_top #(
  parameter int EXP_W      = 11,
  parameter int FRAC_W     = 52,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic                    sel_max,
  input  logic                    sel_jmode,
  input  logic                    inv_en,
  output logic [EXP_W+FRAC_W:0]   res_o,
  output logic                    snan_o,
  output logic                    wr_en_o
);
  localparam int DW = EXP_W + FRAC_W + 1;

  fpmm_pkg::fp_class_t cls [2];
  logic [DW-1:0]       opnd [2];
  logic                a_lt_b;
  logic [DW-1:0]       res_d;
  logic                snan_d;
  logic                wr_en_d;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val (opnd[gi]),
      .cls (cls[gi])
    );
  end

  fpmm_less #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_less (
    .a      (op_a),
    .b      (op_b),
    .ca     (cls[0]),
    .cb     (cls[1]),
    .a_lt_b (a_lt_b)
  );

  fpmm_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
    .a         (op_a),
    .b         (op_b),
    .ca        (cls[0]),
    .cb        (cls[1]),
    .a_lt_b    (a_lt_b),
    .sel_max   (sel_max),
    .sel_jmode (sel_jmode),
    .res       (res_d),
    .snan      (snan_d)
  );

  assign wr_en_d = ~(snan_d & inv_en);

  if (REGISTERED) begin : g_reg
    logic          rst_s1;
    logic          rst_s2;
    logic [DW-1:0] res_q;
    logic          snan_q;
    logic          wr_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_s1 <= 1'b0;
        rst_s2 <= 1'b0;
      end else begin
        rst_s1 <= 1'b1;
        rst_s2 <= rst_s1;
      end
    end

    always_ff @(posedge clk or negedge rst_s2) begin
      if (!rst_s2) begin
        res_q   <= '0;
        snan_q  <= 1'b0;
        wr_en_q <= 1'b0;
      end else begin
        res_q   <= res_d;
        snan_q  <= snan_d;
        wr_en_q <= wr_en_d;
      end
    end

    assign res_o   = res_q;
    assign snan_o  = snan_q;
    assign wr_en_o = wr_en_q;
  end else begin : g_comb
    assign res_o   = res_d;
    assign snan_o  = snan_d;
    assign wr_en_o = wr_en_d;
  end
endmodule

// File: rtl/fpmm_chk.sv
module fpmm_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  sel_jmode,
  input logic                  inv_en,
  input logic [EXP_W+FRAC_W:0] res_o,
  input logic                  snan_o,
  input logic                  wr_en_o
);
  localparam int MSB = EXP_W + FRAC_W;
  localparam logic [MSB:0] NEG_Z = {1'b1, {MSB{1'b0}}};

  logic [1:0] up_cnt;
  logic       armed;
  logic       a_nan, b_nan, a_snan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end
  assign armed  = (up_cnt == 2'd3);
  assign a_nan  = (&op_a[MSB-1:FRAC_W]) && (|op_a[FRAC_W-1:0]);
  assign b_nan  = (&op_b[MSB-1:FRAC_W]) && (|op_b[FRAC_W-1:0]);
  assign a_snan = a_nan && !op_a[FRAC_W-1];

  // R1
  c_nan_takes_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!sel_jmode && (a_nan || b_nan)) |-> res_o == $past(op_b));

  // R3
  j_nan_takes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(sel_jmode && a_nan) |-> res_o == $past(op_a));

  // R3
  a_snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(a_snan) |-> snan_o);

  // R7
  wr_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (wr_en_o == !(snan_o && $past(inv_en))));

  // R8
  res_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (res_o == $past(op_a) || res_o == $past(op_b) ||
               res_o == '0 || res_o == NEG_Z));
endmodule

bind fpmm_top fpmm_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpmm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .sel_jmode (sel_jmode),
  .inv_en    (inv_en),
  .res_o     (res_o),
  .snan_o    (snan_o),
  .wr_en_o   (wr_en_o)
);

// File: tb/tb_fpmm_top.sv
module tb_fpmm_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic        sel_max, sel_jmode, inv_en;
  logic [63:0] res_o;
  logic        snan_o, wr_en_o;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] MONE = 64'hBFF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] MTWO = 64'hC000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000123;
  localparam logic [63:0] SNAN = 64'h7FF0000000000456;
  localparam logic [63:0] SNN  = 64'hFFF4000000000001;

  always #2.5 clk = ~clk;

  fpmm_top dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .sel_max(sel_max), .sel_jmode(sel_jmode), .inv_en(inv_en),
    .res_o(res_o), .snan_o(snan_o), .wr_en_o(wr_en_o)
  );

  function automatic bit is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic bit is_snan(logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  function automatic bit is_zero(logic [63:0] v);
    return v[62:0] == 63'd0;
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b,
                       input bit mx, input bit jm, input bit ie,
                       output logic [63:0] r, output bit sn, output bit we);
    bit lt;
    lt = $bitstoreal(a) < $bitstoreal(b);
    sn = 1'b0;
    if (!jm && (is_nan(a) || is_nan(b))) begin
      r  = b;
      sn = is_snan(a) || is_snan(b);
    end else if (jm && is_nan(a)) begin
      r  = a;
      sn = is_snan(a);
    end else if (jm && is_nan(b)) begin
      r  = b;
      sn = is_snan(b);
    end else if (jm && is_zero(a) && is_zero(b)) begin
      if (mx) r = (a[63] && b[63]) ? NZ : PZ;
      else    r = (a[63] || b[63]) ? NZ : PZ;
    end else if (mx) begin
      r = lt ? b : a;
    end else begin
      r = lt ? a : b;
    end
    we = !(sn && ie);
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input bit mx, input bit jm, input bit ie, input string tag);
    logic [63:0] er;
    bit esn, ewe;
    model(a, b, mx, jm, ie, er, esn, ewe);
    @(negedge clk);
    op_a = a; op_b = b; sel_max = mx; sel_jmode = jm; inv_en = ie;
    @(negedge clk);
    checks++;
    if (res_o !== er || snan_o !== esn || wr_en_o !== ewe) begin
      errors++;
      $display("FAIL %s a=%h b=%h max=%0d j=%0d ie=%0d: got res=%h snan=%0d we=%0d, exp res=%h snan=%0d we=%0d",
               tag, a, b, mx, jm, ie, res_o, snan_o, wr_en_o, er, esn, ewe);
    end
  endtask

  function automatic logic [63:0] pick_val(int sel);
    case (sel % 12)
      0: return PZ;   1: return NZ;   2: return ONE;  3: return MONE;
      4: return PINF; 5: return NINF; 6: return QNAN; 7: return SNAN;
      8: return TWO;  9: return MTWO; 10: return SNN;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_a = ONE; op_b = TWO; sel_max = 1'b1; sel_jmode = 1'b0; inv_en = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (res_o !== 64'd0 || snan_o !== 1'b0 || wr_en_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: got res=%h snan=%0d we=%0d, exp 0/0/0", res_o, snan_o, wr_en_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 compare mode NaN handling
    run(QNAN, ONE,  1, 0, 0, "R1");
    run(ONE,  QNAN, 0, 0, 0, "R1");
    run(SNAN, ONE,  1, 0, 0, "R1");
    run(ONE,  SNAN, 0, 0, 1, "R1");
    run(SNN,  QNAN, 1, 0, 1, "R1");
    // R2 compare mode ordering and ties
    run(ONE,  TWO,  1, 0, 0, "R2");
    run(ONE,  TWO,  0, 0, 0, "R2");
    run(PZ,   NZ,   1, 0, 0, "R2");
    run(PZ,   NZ,   0, 0, 0, "R2");
    run(NZ,   PZ,   1, 0, 0, "R2");
    run(NZ,   PZ,   0, 0, 0, "R2");
    // R3 language mode NaN priority
    run(QNAN, SNAN, 1, 1, 1, "R3");
    run(ONE,  SNAN, 0, 1, 1, "R3");
    run(SNN,  QNAN, 0, 1, 0, "R3");
    run(TWO,  QNAN, 1, 1, 1, "R3");
    // R4 / R5 language mode zeros
    run(PZ, PZ, 1, 1, 0, "R4");
    run(NZ, PZ, 1, 1, 0, "R4");
    run(PZ, NZ, 1, 1, 0, "R4");
    run(NZ, NZ, 1, 1, 0, "R4");
    run(PZ, PZ, 0, 1, 0, "R5");
    run(NZ, PZ, 0, 1, 0, "R5");
    run(PZ, NZ, 0, 1, 0, "R5");
    run(NZ, NZ, 0, 1, 0, "R5");
    // R6 language mode ordered values
    run(MONE, ONE, 1, 1, 0, "R6");
    run(MONE, ONE, 0, 1, 0, "R6");
    run(ONE,  ONE, 0, 1, 0, "R6");
    // R7 write suppression
    run(SNAN, TWO, 1, 0, 1, "R7");
    run(SNAN, TWO, 1, 0, 0, "R7");
    run(QNAN, TWO, 1, 1, 1, "R7");
    // R8 infinities and NaN encodings
    run(PINF, TWO,  0, 0, 0, "R8");
    run(NINF, MTWO, 1, 1, 0, "R8");
    run(64'h7FF0000000000001, ONE, 1, 1, 0, "R8");
    run(64'h7FF8000000000000, ONE, 1, 1, 1, "R8");
    // R9 sign-magnitude ordering
    run(MTWO, MONE, 1, 0, 0, "R9");
    run(MTWO, MONE, 0, 0, 0, "R9");
    run(MONE, PZ,   1, 0, 0, "R9");
    run(NZ,   MONE, 0, 1, 0, "R9");

    // mixed sweep over all controls
    for (int i = 0; i < 2000; i++) begin
      run(pick_val($urandom()), pick_val($urandom()),
          $urandom() % 2, $urandom() % 2, $urandom() % 2, "R2 R6 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule